// File: doc/BRIEF.md
# HDLC Receiver with Threshold FIFO

This block takes a serial HDLC line, one bit per cycle on which a valid strobe is high. It finds the flag patterns that open and close frames and removes the zero inserted after every run of five ones. It assembles the remaining bits into bytes, least significant bit first, and runs a CRC-ITU-T check over each frame. The bytes go into an internal receive FIFO that is built so that a block RAM can hold it. After the data bytes of every frame, the block writes one status byte into the FIFO.

A host drains the FIFO one byte per read strobe. It uses two one-cycle indications for this. The pool-full pulse says that another block of the selected size is waiting. The frame-end pulse says that a frame has closed and its status byte is stored. A configuration input decides whether the two received check bytes are kept in the FIFO ahead of the status byte. In both settings the check is still evaluated.

A two-bit selector picks the block size. The new value is taken only while no frame is being collected, or when the host pulses a receive-memory-clear strobe after it has read a block.

Top module: `hdlc_rx_pool`

## Requirements
- R1: A 0 received after five consecutive 1s is removed from the data. The pattern 01111110 opens and closes frames. Frame bytes are assembled least significant bit first.
- R2: With `keep_fcs` low, the two check bytes that end a frame are not stored. With it high, both are stored after the data, in the order they were received.
- R3: After the frame contents, exactly one status byte is stored. Its fields are: bit 0 is check valid, bit 1 is length valid (at least 4 bytes between flags, check included, and the frame ends on a byte boundary), bit 2 is overflow, bit 3 is aborted, and bits 7:4 are 0.
- R4: The check is computed over all received bytes and counts as valid when the reflected register (preset 0xFFFF, polynomial 0x8408) ends at 0xF0B8. This holds whether or not the check bytes are kept.
- R5: `thr_sel` encodes the block size as 00 = 32 bytes, 01 = 16, 10 = 4 and 11 = 2. After reset the active value is 00.
- R6: `pool_full` is a one-cycle pulse. It fires on each stored byte that brings the count since the last pulse or the last status byte up to the active block size. A stored status byte clears that count.
- R7: The active block size follows `thr_sel` only while no frame byte is pending or being flushed, or in a cycle where `rmc` is high. Otherwise a change of `thr_sel` has no effect.
- R8: `frame_end` pulses for one cycle in the cycle after a status byte is stored.
- R9: Seven consecutive 1s abort a frame that has received bytes. The two most recent bytes are dropped and status 0x08 is stored. Reception then waits for the next flag.
- R10: A data byte is stored only while at least two FIFO entries are free. Otherwise it is dropped and the overflow bit is set. The last entry is reserved for the status byte.
- R11: Flags with no complete byte between them store nothing and raise no pulse.
- R12: When `rd_en` is high and the FIFO is not empty, `rd_valid` is high in the next cycle with the oldest byte on `rd_data`. `level` gives the number of stored bytes.
- R13: After reset the FIFO is empty and `rd_valid`, `pool_full` and `frame_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_vld | input | 1 | Line bit valid strobe |
| rx_bit | input | 1 | Line bit |
| keep_fcs | input | 1 | Keep the received check bytes in the FIFO |
| thr_sel | input | 2 | Block size select |
| rmc | input | 1 | Receive-memory-clear strobe; lets a new block size take effect |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | rd_data holds a byte this cycle |
| level | output | $clog2(DEPTH+1) | Bytes stored |
| pool_full | output | 1 | A block of the selected size is ready |
| frame_end | output | 1 | A status byte has just been stored |

## Verification
The bench sweeps frame lengths from 1 to 24 bytes under all four block sizes and both check-byte settings. The payloads are full of 0xFF and 0x7E, so that stuffing occurs inside data and check bytes. A design with a broken destuffer or a wrong bit order would corrupt the bytes, and an off-by-one in the block count would produce the wrong number of pool-full pulses. Some frames carry a damaged check, and a one-byte frame must be flagged short. This catches a check that is only evaluated when the bytes are dropped, and a length test that counts payload only. Other cases cover an abort after three bytes (a design that stores the pending bytes would show them), a frame that overruns the FIFO (the status byte must still land with overflow set), and changes of the block size in mid-frame both with and without the clear strobe (a design that takes the new size at once would pulse early).

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_RESID  = 16'hF0B8;

  // status byte field positions
  localparam int ST_CRC = 0;
  localparam int ST_LEN = 1;
  localparam int ST_OVF = 2;
  localparam int ST_ABT = 3;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction

  function automatic logic [5:0] blk_size(input logic [1:0] sel);
    case (sel)
      2'b00:   return 6'd32;
      2'b01:   return 6'd16;
      2'b10:   return 6'd4;
      default: return 6'd2;
    endcase
  endfunction
endpackage

// File: rtl/hdlc_bit_slicer.sv
module hdlc_bit_slicer (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       bit_in,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic       flag_hit,
  output logic       flag_aligned,
  output logic       abort_hit
);
  logic [2:0] ones;
  logic [2:0] bcnt;
  logic [7:0] sr;
  logic       in_frame;
  logic       is_stuff, is_flag, is_abort;

  assign is_stuff = !bit_in && (ones == 3'd5);
  assign is_flag  = !bit_in && (ones == 3'd6);
  assign is_abort =  bit_in && (ones == 3'd6);

  always_ff @(posedge clk) begin
    byte_vld  <= 1'b0;
    flag_hit  <= 1'b0;
    abort_hit <= 1'b0;
    if (rst) begin
      ones <= '0; bcnt <= '0; sr <= '0; in_frame <= 1'b0;
      byte_data <= '0; flag_aligned <= 1'b0;
    end else if (bit_vld) begin
      ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
      if (is_flag) begin
        flag_hit     <= 1'b1;
        flag_aligned <= in_frame && (bcnt == 3'd7);
        in_frame     <= 1'b1;
        bcnt         <= '0;
      end else if (is_abort) begin
        abort_hit <= in_frame;
        in_frame  <= 1'b0;
        bcnt      <= '0;
      end else if (in_frame && !is_stuff) begin
        sr   <= {bit_in, sr[7:1]};
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {bit_in, sr[7:1]};
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_frame_ctl.sv
module hdlc_frame_ctl
  import hdlc_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       keep_fcs,
  input  logic       byte_vld,
  input  logic [7:0] byte_data,
  input  logic       flag_hit,
  input  logic       flag_aligned,
  input  logic       abort_hit,
  input  logic       room_data,
  output logic       wr_req,
  output logic       wr_stat,
  output logic [7:0] wr_data,
  output logic       busy
);
  logic [7:0]  pend0, pend1;   // pend1 is the older byte
  logic [1:0]  pcnt;
  logic [2:0]  fbytes;         // saturating byte count of the current frame
  logic [15:0] crc;
  logic        fl, st_crc, st_len, st_abt, ovf;

  always_comb begin
    wr_req  = 1'b0;
    wr_stat = 1'b0;
    wr_data = pend1;
    if (fl) begin
      wr_req = 1'b1;
      if (pcnt == 2'd2)      wr_data = pend1;
      else if (pcnt == 2'd1) wr_data = pend0;
      else begin
        wr_stat = 1'b1;
        wr_data = '0;
        wr_data[ST_CRC] = st_crc;
        wr_data[ST_LEN] = st_len;
        wr_data[ST_OVF] = ovf;
        wr_data[ST_ABT] = st_abt;
      end
    end else if (byte_vld && pcnt == 2'd2) begin
      wr_req = 1'b1;
    end
  end

  assign busy = fl || (fbytes != 3'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend0 <= '0; pend1 <= '0; pcnt <= '0; fbytes <= '0; crc <= CRC_PRESET;
      fl <= 1'b0; st_crc <= 1'b0; st_len <= 1'b0; st_abt <= 1'b0; ovf <= 1'b0;
    end else begin
      if (wr_req && !wr_stat && !room_data) ovf <= 1'b1;
      if (byte_vld) begin
        pend1  <= pend0;
        pend0  <= byte_data;
        pcnt   <= (pcnt == 2'd2) ? 2'd2 : pcnt + 2'd1;
        crc    <= crc_step(crc, byte_data);
        fbytes <= (fbytes == 3'd7) ? 3'd7 : fbytes + 3'd1;
      end
      if (fl) begin
        if (pcnt != 2'd0) pcnt <= pcnt - 2'd1;
        else begin
          fl  <= 1'b0;
          ovf <= 1'b0;
        end
      end
      if (flag_hit) begin
        if (fbytes != 3'd0) begin
          fl     <= 1'b1;
          st_crc <= (crc == CRC_RESID);
          st_len <= (fbytes >= 3'd4) && flag_aligned;
          st_abt <= 1'b0;
          if (!keep_fcs) pcnt <= '0;
        end
        fbytes <= '0;
        crc    <= CRC_PRESET;
      end else if (abort_hit && fbytes != 3'd0) begin
        fl     <= 1'b1;
        st_crc <= 1'b0;
        st_len <= 1'b0;
        st_abt <= 1'b1;
        pcnt   <= '0;
        fbytes <= '0;
        crc    <= CRC_PRESET;
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
  parameter int DEPTH = 64   // power of two
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_req,
  input  logic                       wr_stat,
  input  logic [7:0]                 wr_data,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       room_data,
  output logic                       wr_done
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] cnt;
  logic          room_stat, rd_go;

  assign room_data = cnt < LW'(DEPTH - 1);
  assign room_stat = cnt < LW'(DEPTH);
  assign wr_done   = wr_req && (wr_stat ? room_stat : room_data);
  assign rd_go     = rd_en && (cnt != '0);
  assign level     = cnt;

  always_ff @(posedge clk) begin
    if (wr_done) mem[wr_ptr] <= wr_data;
    if (rd_go)   rd_data <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_go;
      if (wr_done) wr_ptr <= wr_ptr + AW'(1);
      if (rd_go)   rd_ptr <= rd_ptr + AW'(1);
      case ({wr_done, rd_go})
        2'b10:   cnt <= cnt + LW'(1);
        2'b01:   cnt <= cnt - LW'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_rx_pool.sv
module hdlc_rx_pool
  import hdlc_rx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rx_vld,
  input  logic                       rx_bit,
  input  logic                       keep_fcs,
  input  logic [1:0]                 thr_sel,
  input  logic                       rmc,
  input  logic                       rd_en,
  output logic [7:0]                 rd_data,
  output logic                       rd_valid,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       pool_full,
  output logic                       frame_end
);
  logic       byte_vld, flag_hit, flag_aligned, abort_hit;
  logic [7:0] byte_data, wr_data;
  logic       wr_req, wr_stat, room_data, wr_done, busy;
  logic [1:0] act_thr;
  logic [5:0] blk_cnt, blk_nxt, size;

  hdlc_bit_slicer u_slicer (
    .clk, .rst, .bit_vld(rx_vld), .bit_in(rx_bit),
    .byte_vld, .byte_data, .flag_hit, .flag_aligned, .abort_hit
  );

  hdlc_frame_ctl u_frame (
    .clk, .rst, .keep_fcs, .byte_vld, .byte_data, .flag_hit, .flag_aligned,
    .abort_hit, .room_data, .wr_req, .wr_stat, .wr_data, .busy
  );

  hdlc_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk, .rst, .wr_req, .wr_stat, .wr_data, .rd_en,
    .rd_data, .rd_valid, .level, .room_data, .wr_done
  );

  assign size    = blk_size(act_thr);
  assign blk_nxt = blk_cnt + 6'd1;

  always_ff @(posedge clk) begin
    pool_full <= 1'b0;
    frame_end <= 1'b0;
    if (rst) begin
      act_thr <= 2'b00;
      blk_cnt <= '0;
    end else begin
      if (!busy || rmc) act_thr <= thr_sel;
      if (wr_done) begin
        pool_full <= (blk_nxt >= size);
        if (wr_stat) begin
          frame_end <= 1'b1;
          blk_cnt   <= '0;
        end else begin
          blk_cnt <= (blk_nxt >= size) ? 6'd0 : blk_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_rx_pool_chk.sv
module hdlc_rx_pool_chk #(
  parameter int DEPTH = 64
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       pool_full,
  input logic                       frame_end,
  input logic                       rd_en,
  input logic                       rd_valid,
  input logic [$clog2(DEPTH+1)-1:0] level,
  input logic [1:0]                 act_thr,
  input logic [1:0]                 thr_sel,
  input logic                       busy,
  input logic                       rmc
);
  assert_pool_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    pool_full |=> !pool_full);

  assert_frame_end_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  assert_level_bound_R10: assert property (@(posedge clk) disable iff (rst)
    level <= ($clog2(DEPTH+1))'(DEPTH));

  assert_read_follows_R12: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en));

  assert_thr_window_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_thr) |-> $past(!busy || rmc));

  assert_thr_source_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_thr) |-> (act_thr == $past(thr_sel)));
endmodule

bind hdlc_rx_pool hdlc_rx_pool_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .pool_full(pool_full), .frame_end(frame_end),
  .rd_en(rd_en), .rd_valid(rd_valid), .level(level), .act_thr(act_thr),
  .thr_sel(thr_sel), .busy(busy), .rmc(rmc)
);

// File: tb/hdlc_rx_pool_tb.sv
module hdlc_rx_pool_tb;
  localparam int DEPTH = 64;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_vld = 1'b0, rx_bit = 1'b0, keep_fcs = 1'b0, rmc = 1'b0, rd_en = 1'b0;
  logic [1:0] thr_sel = 2'b00;
  logic [7:0] rd_data;
  logic rd_valid, pool_full, frame_end;
  logic [LW-1:0] level;

  always #2.5 clk = ~clk;

  hdlc_rx_pool #(.DEPTH(DEPTH)) u_dut (
    .clk, .rst, .rx_vld, .rx_bit, .keep_fcs, .thr_sel, .rmc, .rd_en,
    .rd_data, .rd_valid, .level, .pool_full, .frame_end
  );

  int n_run = 0, n_fail = 0, pools = 0, fends = 0, ones_tx = 0, ngot = 0, nexp = 0;
  bit finished = 0;
  logic [7:0] pay [0:79];
  logic [7:0] got [0:127];
  logic [7:0] expv [0:127];

  always @(negedge clk) begin
    if (pool_full) pools++;
    if (frame_end) fends++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c ^ {8'h00, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  function automatic int bsize(input logic [1:0] s);
    return (s == 2'b00) ? 32 : (s == 2'b01) ? 16 : (s == 2'b10) ? 4 : 2;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); rx_vld = 1'b1; rx_bit = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); rx_vld = 1'b0; end
  endtask

  task automatic send_flag();
    for (int i = 0; i < 8; i++) send_bit((i == 0 || i == 7) ? 1'b0 : 1'b1);
    ones_tx = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      ones_tx = b[i] ? ones_tx + 1 : 0;
      if (ones_tx == 5) begin send_bit(1'b0); ones_tx = 0; end
    end
  endtask

  function automatic logic [15:0] fcs_of(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) c = crc_b(c, pay[i]);
    return ~c;
  endfunction

  task automatic close_frame(input int n, input bit corrupt);
    logic [15:0] f = fcs_of(n);
    send_byte(f[7:0] ^ (corrupt ? 8'h04 : 8'h00));
    send_byte(f[15:8]);
    send_flag();
    idle(12);
  endtask

  task automatic send_frame(input int n, input bit corrupt);
    send_flag();
    for (int i = 0; i < n; i++) send_byte(pay[i]);
    close_frame(n, corrupt);
  endtask

  task automatic drain();
    ngot = 0;
    while (level != '0) begin
      @(negedge clk) rd_en = 1'b1;
      @(negedge clk) rd_en = 1'b0;
      if (!rd_valid) check(0, "R12", "rd_valid after read", 0, 1);
      got[ngot] = rd_data;
      ngot++;
    end
  endtask

  task automatic expect_frame(input int n, input bit keep, input bit corrupt, input bit ovf, input int kept);
    logic [15:0] f = fcs_of(n);
    nexp = 0;
    for (int i = 0; i < kept; i++) begin expv[nexp] = pay[i]; nexp++; end
    if (keep) begin
      expv[nexp] = f[7:0] ^ (corrupt ? 8'h04 : 8'h00); nexp++;
      expv[nexp] = f[15:8]; nexp++;
    end
    expv[nexp] = {4'h0, 1'b0, ovf, ((n + 2) >= 4), !corrupt}; nexp++;
  endtask

  task automatic cmp_fifo(input string req);
    bit ok = (ngot == nexp);
    int bad = -1;
    for (int i = 0; i < nexp && i < ngot; i++)
      if (got[i] !== expv[i] && bad < 0) begin ok = 0; bad = i; end
    if (bad >= 0) check(ok, req, $sformatf("byte %0d", bad), got[bad], expv[bad]);
    else          check(ok, req, "byte count", ngot, nexp);
  endtask

  function automatic int model_pools(input int w, input int sw_at, input int b0, input int b1);
    int cnt = 0, p = 0;
    for (int i = 1; i <= w; i++) begin
      if (cnt + 1 >= ((i <= sw_at) ? b0 : b1)) begin p++; cnt = 0; end else cnt++;
    end
    return p;
  endfunction

  initial begin
    #(190000 * 5);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    check(level == 0, "R13", "level after reset", level, 0);
    check(!rd_valid && !pool_full && !frame_end, "R13", "outputs after reset",
          {rd_valid, pool_full, frame_end}, 0);

    // R12 read on empty FIFO
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    check(!rd_valid, "R12", "read when empty", rd_valid, 0);

    // R11 flags only
    pools = 0; fends = 0;
    for (int i = 0; i < 5; i++) send_flag();
    idle(12);
    check(level == 0 && fends == 0 && pools == 0, "R11", "stored after bare flags", level, 0);

    // R1 R2 R3 R4 R5 R6 R8 sweep
    for (int t = 0; t < 4; t++)
      for (int k = 0; k < 2; k++)
        for (int n = 1; n <= 24; n++) begin
          bit corrupt = (n % 5 == 3);
          thr_sel = 2'(t); keep_fcs = 1'(k);
          idle(2);
          for (int i = 0; i < n; i++)
            pay[i] = (i % 7 == 3) ? 8'hFF : (i % 7 == 5) ? 8'h7E : 8'(n * 29 + i * 53 + t * 7 + k);
          pools = 0; fends = 0;
          send_frame(n, corrupt);
          expect_frame(n, k, corrupt, 0, n);
          check(pools == nexp / bsize(2'(t)), "R5/R6", "pool_full pulses", pools, nexp / bsize(2'(t)));
          check(fends == 1, "R8", "frame_end pulses", fends, 1);
          drain();
          cmp_fifo(k ? "R2/R3/R4 kept" : "R1/R2/R3 dropped");
        end

    // R9 abort after three bytes, then recovery
    keep_fcs = 1'b0; thr_sel = 2'b00; idle(2);
    pools = 0; fends = 0;
    send_flag();
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'h12);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    idle(12);
    drain();
    check(ngot == 2 && got[0] == 8'hA1 && got[1] == 8'h08, "R9", "abort contents",
          {got[0], got[1]}, 16'hA108);
    check(fends == 1, "R9", "frame_end on abort", fends, 1);
    for (int i = 0; i < 3; i++) pay[i] = 8'(8'h31 + i);
    send_frame(3, 0);
    drain();
    expect_frame(3, 0, 0, 0, 3);
    cmp_fifo("R9 recovery");

    // R10 overflow: 70 bytes, no reads
    for (int i = 0; i < 70; i++) pay[i] = 8'(i * 11 + 3);
    pools = 0; fends = 0;
    send_frame(70, 0);
    check(level == DEPTH, "R10", "level after overflow", level, DEPTH);
    check(pools == 2, "R10/R6", "pools with dropped bytes", pools, 2);
    drain();
    expect_frame(70, 0, 0, 1, DEPTH - 1);
    cmp_fifo("R10");

    // R7 change of thr_sel inside a frame has no effect
    thr_sel = 2'b00; idle(2);
    for (int i = 0; i < 10; i++) pay[i] = 8'(i * 5 + 1);
    pools = 0;
    send_flag();
    for (int i = 0; i < 3; i++) send_byte(pay[i]);
    thr_sel = 2'b11;
    for (int i = 3; i < 10; i++) send_byte(pay[i]);
    close_frame(10, 0);
    check(pools == 0, "R7", "pools with change mid-frame", pools, 0);
    drain();
    pools = 0;
    send_frame(10, 0);
    check(pools == 5, "R7", "pools after idle update", pools, 5);
    drain();

    // R7 rmc lets a change take effect mid-frame
    thr_sel = 2'b00; idle(2);
    for (int i = 0; i < 20; i++) pay[i] = 8'(i * 9 + 2);
    pools = 0;
    send_flag();
    for (int i = 0; i < 8; i++) send_byte(pay[i]);
    idle(4);
    check(pools == 0, "R7", "pools before clear", pools, 0);
    thr_sel = 2'b10;
    @(negedge clk) rmc = 1'b1;
    @(negedge clk) rmc = 1'b0;
    for (int i = 8; i < 20; i++) send_byte(pay[i]);
    close_frame(20, 0);
    check(pools == model_pools(21, 6, 32, 4), "R7", "pools after clear", pools, model_pools(21, 6, 32, 4));
    drain();
    expect_frame(20, 0, 0, 0, 20);
    cmp_fifo("R7 contents");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule